// File: doc/BRIEF.md
# Buffered Variable-Frequency PWM Channel

This block is a single timer channel that produces a pulse-width-modulated output. Software programs both the position of the duty edge and the length of the period. An internal counter advances on prescaled clock ticks. It starts at 1, climbs to the active period value, and then restarts at 1.

A duty compare drives the pin to the level given by the polarity input. The period compare drives it back to the opposite level. Software writes through a small register port into shadow copies of the duty and period values. The channel moves the shadow copies into the active compare registers only when a new cycle begins, so a cycle in flight is never altered.

Every pin edge comes one system clock after the matching counter value ends, not when that value begins. This gives evenly spaced edges and clean extreme duty settings.

Top module: `pwm_buffered_channel`

## Requirements
- R1: The counter is 1 after reset. It holds while `enable` is low. It never takes the value 0 and never exceeds the active period while running.
- R2: When the counter is at the active period value, the next tick returns it to 1. That tick starts a new PWM cycle.
- R3: Timing of the output. Let the first clock edge with `enable` high be edge 0, the prescale divide be P, the active duty be D and the active period be N. If 1 <= D < N, the pin goes to the active level at edge D*P and returns to the inactive level at edge N*P. The pattern then repeats every N*P edges.
- R4: Writes go to shadow registers. While the channel runs, the active duty and period change only at a cycle restart. While `enable` is low, the active registers follow the shadows.
- R5: The prescaler divides the system clock by `prescSel`+1, which is 1 to 4. It starts counting from zero when the channel is enabled.
- R6: A period write (`wrSel`=1) with data 0 or 1 is ignored, and `wrError` is high for the one clock after that write edge. A duty write (`wrSel`=0) is always accepted and never raises `wrError`.
- R7: If the duty and period matches fall on the same count (D = N), the period match wins and the pin stays at the inactive level.
- R8: If the active duty is greater than the active period, or is 0, no duty match occurs. The pin stays at the inactive level for the whole cycle, which gives 0% duty.
- R9: In reset the pin shows the inactive level, which is the complement of `polarity`. The shadow and active registers reset to 0.
- R10: The active level of the pin equals the `polarity` input. The inactive level is its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the counter and prescaler when high |
| prescSel | input | 2 | Prescale select; the divide ratio is the value plus 1 |
| polarity | input | 1 | Pin level driven on a duty match |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 selects duty, 1 selects period |
| wrData | input | CNT_W | Write data |
| wrError | output | 1 | One-clock flag for a rejected period write |
| pwmOut | output | 1 | PWM output pin |

## Verification
The bench measures edge positions against the D*P and N*P formula for several prescale ratios and both polarities. A design that switched the pin when a match begins, rather than when it ends, would put every edge one counter period early.

It changes the shadow registers partway through a running cycle and expects the new waveform to start exactly at the next restart. A design that loaded the active registers directly would break the current cycle.

It also drives D = N and D > N and expects a pin that stays inactive, which catches a wrong match priority. Finally, it writes periods of 0 and 1 and expects a flag and an unchanged waveform, which catches a design that accepts illegal periods.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Write target on the register port
  typedef enum logic {
    SEL_DUTY   = 1'b0,
    SEL_PERIOD = 1'b1
  } wrTarget_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;        // counter advances this clock
    logic restart;     // counter returns to 1 this clock
    logic loadActive;  // shadow copies move into active registers
  } ctlStrobe_t;

  localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             dutyHit,
  output logic             periodHit,
  output logic             badPeriodWr
);

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] shadowDuty;
  logic [CNT_W-1:0] shadowPeriod;
  logic [CNT_W-1:0] activeDuty;
  logic [CNT_W-1:0] activePeriod;
  logic [CNT_W-1:0] cnt;

  logic dutyWr;
  logic periodWr;

  // Write decode; illegal period values are rejected
  always_comb begin
    dutyWr      = wrEn && (wrTarget_e'(wrSel) == SEL_DUTY);
    periodWr    = wrEn && (wrTarget_e'(wrSel) == SEL_PERIOD);
    badPeriodWr = periodWr && (wrData < MIN_PER);
  end

  // Shadow registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowDuty   <= '0;
      shadowPeriod <= '0;
    end else begin
      if (dutyWr) begin
        shadowDuty <= wrData;
      end
      if (periodWr && !badPeriodWr) begin
        shadowPeriod <= wrData;
      end
    end
  end

  // Active registers, loaded at cycle restart or while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDuty   <= '0;
      activePeriod <= '0;
    end else if (strb.loadActive) begin
      activeDuty   <= shadowDuty;
      activePeriod <= shadowPeriod;
    end
  end

  // Channel counter, range 1..period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= ONE;
    end else if (strb.tick) begin
      if (strb.restart) begin
        cnt <= ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  // Comparators; period uses >= so a stale counter above period restarts
  always_comb begin
    dutyHit   = (cnt == activeDuty);
    periodHit = (cnt >= activePeriod);
  end

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0); // R1

  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.restart) |=> (cnt == ONE)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.restart) |=> (cnt == $past(cnt) + ONE)); // R1

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadActive |=> ($stable(activeDuty) && $stable(activePeriod))); // R4

  AST_BAD_PERIOD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    badPeriodWr |=> $stable(shadowPeriod)); // R6

endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int unsigned PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic               polarity,
  input  logic               dutyHit,
  input  logic               periodHit,
  input  logic               badPeriodWr,
  output ctlStrobe_t         strb,
  output logic               wrError,
  output logic               pwmOut
);

  logic [PRESC_W-1:0] preCnt;
  logic               tick;
  logic               tickQ;
  logic               dutyHitQ;
  logic               periodHitQ;
  logic               dutyFall;
  logic               periodFall;
  logic               outActive;

  // Prescaler: ratio prescSel+1, held at zero while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!enable || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRESC_W'(1);
    end
  end

  always_comb begin
    tick            = enable && (preCnt == prescSel);
    strb.tick       = tick;
    strb.restart    = tick && periodHit;
    strb.loadActive = (tick && periodHit) || !enable;
  end

  // Match pulses end when the counter moves off the matching value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ      <= 1'b0;
      dutyHitQ   <= 1'b0;
      periodHitQ <= 1'b0;
    end else begin
      tickQ      <= tick;
      dutyHitQ   <= dutyHit;
      periodHitQ <= periodHit;
    end
  end

  always_comb begin
    dutyFall   = tickQ && dutyHitQ;
    periodFall = tickQ && periodHitQ;
  end

  // Output state; period match takes precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outActive <= 1'b0;
    end else if (periodFall) begin
      outActive <= 1'b0;
    end else if (dutyFall) begin
      outActive <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrError <= 1'b0;
    end else begin
      wrError <= badPeriodWr;
    end
  end

  assign pwmOut = outActive ? polarity : ~polarity;

  AST_PERIOD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    periodFall |=> !outActive); // R7

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strb.tick); // R1

  AST_PRESC_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |-> (strb.tick == (prescSel == '0))); // R5

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (wrError && !badPeriodWr) |=> !wrError); // R6

endmodule

// File: rtl/pwm_buffered_channel.sv
module pwm_buffered_channel
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic               polarity,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [CNT_W-1:0]   wrData,
  output logic               wrError,
  output logic               pwmOut
);

  ctlStrobe_t strb;
  logic       dutyHit;
  logic       periodHit;
  logic       badPeriodWr;

  pwm_chan_ctrl #(.PRESC_W(PRESC_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .prescSel   (prescSel),
    .polarity   (polarity),
    .dutyHit    (dutyHit),
    .periodHit  (periodHit),
    .badPeriodWr(badPeriodWr),
    .strb       (strb),
    .wrError    (wrError),
    .pwmOut     (pwmOut)
  );

  pwm_chan_datapath #(.CNT_W(CNT_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .dutyHit    (dutyHit),
    .periodHit  (periodHit),
    .badPeriodWr(badPeriodWr)
  );

  AST_RESET_LEVEL: assert property (@(posedge clk)
    !rstN |-> (pwmOut == ~polarity)); // R9

endmodule

// File: tb/tb_pwm_buffered_channel.sv
module tb_pwm_buffered_channel;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [1:0]       prescSel = 2'd0;
  logic             polarity = 1'b1;
  logic             wrEn = 1'b0;
  logic             wrSel = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic             wrError;
  logic             pwmOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_buffered_channel dut (
    .clk(clk), .rstN(rstN), .enable(enable), .prescSel(prescSel),
    .polarity(polarity), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrError(wrError), .pwmOut(pwmOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Active-level expectation from R3/R7/R8
  function automatic bit expActive(int t, int d, int n, int p);
    if (d < 1 || d >= n) return 1'b0;
    return (t % (n * p)) >= d * p;
  endfunction

  task automatic doReset(input bit pol);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; polarity = pol; wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pwmOut == ~pol, "R9 reset level", pwmOut, ~pol);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input bit sel, input int val);
    wrEn = 1'b1; wrSel = sel; wrData = CNT_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Runs a waveform, optionally injecting one write at edge injT
  task automatic runWave(input string req, input bit pol, input int d, input int n,
                         input int psel, input int len, input int injT,
                         input bit injSel, input int injData, input bit expErr);
    int bad = 0;
    int badT = -1;
    bit badAct = 0;
    bit badExp = 0;
    doReset(pol);
    prescSel = 2'(psel);
    writeReg(1'b0, d);
    writeReg(1'b1, n);
    @(negedge clk);
    enable = 1'b1;
    for (int t = 0; t < len; t++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        bit e = expActive(t, d, n, psel + 1) ? pol : ~pol;
        if (pwmOut != e) begin
          bad++;
          if (badT < 0) begin badT = t; badAct = pwmOut; badExp = e; end
        end
      end
      if (t == injT + 1) begin
        wrEn = 1'b0;
        check(wrError == expErr, {req, " R6 flag"}, wrError, expErr);
      end
      if (t == injT) begin
        wrEn = 1'b1; wrSel = injSel; wrData = CNT_W'(injData);
      end
    end
    enable = 1'b0;
    if (bad != 0) $display("  first mismatch at edge %0d", badT);
    check(bad == 0, req, badAct, badExp);
  endtask

  // R4: new shadows written mid-cycle take effect at the next restart
  task automatic bufferedUpdate();
    int bad = 0;
    doReset(1'b1);
    prescSel = 2'd0;
    writeReg(1'b0, 2);
    writeReg(1'b1, 4);
    @(negedge clk);
    enable = 1'b1;
    for (int t = 0; t < 40; t++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        bit e;
        if (t < 8) e = expActive(t, 2, 4, 1);
        else e = ((t - 8) % 6) >= 3;
        if (pwmOut != e) begin
          bad++;
          if (bad == 1) $display("FAIL R4 edge %0d: actual=%0d expected=%0d", t, pwmOut, e);
        end
      end
      wrEn = 1'b0;
      if (t == 4) begin wrEn = 1'b1; wrSel = 1'b1; wrData = CNT_W'(6); end
      if (t == 5) begin wrEn = 1'b1; wrSel = 1'b0; wrData = CNT_W'(3); end
    end
    enable = 1'b0;
    tests++;
    if (bad != 0) fails++;
  endtask

  initial begin
    // R9 reset levels for both polarities
    doReset(1'b0);
    // R3 R10 R5: divide 1, active high
    runWave("R3 d3 n5 div1", 1'b1, 3, 5, 0, 40, -5, 1'b0, 0, 1'b0);
    // R5 R10: divide 3, active low
    runWave("R5 d2 n4 div3 pol0", 1'b0, 2, 4, 2, 60, -5, 1'b0, 0, 1'b0);
    // R5 R3: divide 4, duty 4 of period 6
    runWave("R5 d4 n6 div4", 1'b1, 4, 6, 3, 80, -5, 1'b0, 0, 1'b0);
    // R8: duty above period gives 0%
    runWave("R8 d7 n5", 1'b1, 7, 5, 0, 30, -5, 1'b0, 0, 1'b0);
    // R7: coincident matches, period wins
    runWave("R7 d5 n5", 1'b1, 5, 5, 1, 40, -5, 1'b0, 0, 1'b0);
    // R4: mid-cycle reprogram
    bufferedUpdate();
    // R6: period 0 and 1 rejected, waveform unchanged
    runWave("R6 period0 ignored", 1'b1, 2, 4, 0, 30, 4, 1'b1, 0, 1'b1);
    runWave("R6 period1 ignored", 1'b1, 2, 4, 0, 30, 9, 1'b1, 1, 1'b1);
    // R6: duty write never flags
    runWave("R6 duty write ok", 1'b1, 2, 4, 0, 30, 4, 1'b0, 2, 1'b0);
    // R1: counter holds while disabled, pin stays inactive
    doReset(1'b1);
    writeReg(1'b0, 1);
    writeReg(1'b1, 3);
    repeat (10) @(negedge clk);
    check(pwmOut == 1'b0, "R1 hold while disabled", pwmOut, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule